// File: doc/BRIEF.md
# Logical Execute Unit with Condition Flags

This block is the logical slice of a small processor's execute stage. It performs two operations on a destination and a source operand. The first is exclusive-OR, and it writes its result back to the destination. The second is a masked bit test: it ANDs the two operands and updates only the condition flags, with no write-back. The block owns the processor's eight-bit flags byte and updates each bit by its own rule. Software can also overwrite the whole byte through a separate write request. This is how the two general-purpose user bits are set or cleared.

The surrounding pipeline presents the operands and the operation select together with a one-cycle valid strobe. One clock later the block shows the following on its registered outputs:
- the computed value;
- a one-cycle destination write enable, raised for exclusive-OR only;
- the updated flags byte;
- the four flags that branch logic may test.

Top module: `logic_flag_unit`

## Requirements
- R1: With `op_valid`=1 and `op_sel`=0 (exclusive-OR), on the next cycle `result` equals `dst_in ^ src_in` and `dst_we` is 1 for exactly that one cycle.
- R2: With `op_valid`=1 and `op_sel`=1 (masked test), on the next cycle `result` equals `dst_in & src_in` and `dst_we` stays 0.
- R3: Every accepted operation clears the overflow flag, which is `flags[4]`.
- R4: Every accepted operation sets the zero flag (`flags[6]`) when all result bits are 0, and clears it otherwise. It also copies the result's top bit into the sign flag (`flags[5]`).
- R5: Accepted operations leave carry (`flags[7]`), decimal-adjust (`flags[3]`) and half-carry (`flags[2]`) at their previous values.
- R6: The user bits, F2 (`flags[1]`) and F1 (`flags[0]`), are never changed by an operation.
- R7: With `fw_req`=1, the whole flags byte is replaced by `fw_data` on the next cycle.
- R8: When `fw_req` and `op_valid` are both 1 in the same cycle, the flags take `fw_data`. The operation's `result` and `dst_we` still behave as in R1/R2.
- R9: `cond_c`, `cond_z`, `cond_s` and `cond_v` always equal `flags[7]`, `flags[6]`, `flags[5]` and `flags[4]` respectively.
- R10: After reset, `flags`, `result` and `dst_we` are all 0.
- R11: In a cycle with neither `op_valid` nor `fw_req`, the flags and `result` keep their values and `dst_we` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_sel | input | 1 | 0 = exclusive-OR with write-back, 1 = masked test |
| dst_in | input | 8 | Destination operand |
| src_in | input | 8 | Source operand |
| fw_req | input | 1 | Explicit flags-byte write request |
| fw_data | input | 8 | Byte written to the flags on `fw_req` |
| result | output | 8 | Registered value of the last operation |
| dst_we | output | 1 | Destination write enable, one cycle per exclusive-OR |
| flags | output | 8 | Flags byte: C, Z, S, V, D, H, F2, F1 from bit 7 down to bit 0 |
| cond_c | output | 1 | Testable carry |
| cond_z | output | 1 | Testable zero |
| cond_s | output | 1 | Testable sign |
| cond_v | output | 1 | Testable overflow |

## Verification
The bench first loads all ones into the flags and then runs operations on top of them. A design that treated carry, decimal-adjust, half-carry or the user bits as outputs of the operation would drop them to 0 there. It drives equal operands to reach a zero result, and operands with bit 7 set to reach a negative result. These catch an inverted zero test or a sign taken from the wrong bit. It also issues a flags write in the same cycle as an operation. A design that gave the operation priority would show computed flags instead of the written byte. Masked tests mixed among exclusive-ORs expose any stray write enable, and idle gaps expose flags or results that drift.

// File: rtl/logic_flag_unit_pkg.sv
package logic_flag_unit_pkg;

  typedef enum logic [0:0] {
    LU_XOR  = 1'b0,
    LU_TEST = 1'b1
  } lu_op_e;

  localparam int FLAG_W  = 8;
  localparam int FL_C    = 7;
  localparam int FL_Z    = 6;
  localparam int FL_S    = 5;
  localparam int FL_V    = 4;
  localparam int FL_D    = 3;
  localparam int FL_H    = 2;
  localparam int FL_F2   = 1;
  localparam int FL_F1   = 0;

  // Apply the per-bit rules of a logical operation to the current flags.
  function automatic logic [FLAG_W-1:0] lu_merge_flags(
    input logic [FLAG_W-1:0] cur,
    input logic              is_zero,
    input logic              is_neg
  );
    logic [FLAG_W-1:0] nf;
    nf       = cur;
    nf[FL_Z] = is_zero;
    nf[FL_S] = is_neg;
    nf[FL_V] = 1'b0;
    return nf;
  endfunction

endpackage

// File: rtl/lu_operate.sv
module lu_operate
  import logic_flag_unit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  lu_op_e            op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] value,
  output logic              value_zero,
  output logic              value_neg,
  output logic              wants_wb
);

  localparam int MSB = DATA_W - 1;

  always_comb begin
    unique case (op)
      LU_XOR:  value = opa ^ opb;
      default: value = opa & opb;
    endcase
  end

  assign value_zero = ~|value;
  assign value_neg  = value[MSB];
  assign wants_wb   = (op == LU_XOR);

endmodule

// File: rtl/lu_flag_next.sv
module lu_flag_next
  import logic_flag_unit_pkg::*;
(
  input  logic [FLAG_W-1:0] cur_flags,
  input  logic              op_fire,
  input  logic              res_zero,
  input  logic              res_neg,
  input  logic              wr_req,
  input  logic [FLAG_W-1:0] wr_data,
  output logic [FLAG_W-1:0] nxt_flags,
  output logic              ev_op_update,
  output logic              ev_sw_write
);

  assign ev_sw_write  = wr_req;
  assign ev_op_update = op_fire & ~wr_req;

  always_comb begin
    if (wr_req)
      nxt_flags = wr_data;
    else if (op_fire)
      nxt_flags = lu_merge_flags(cur_flags, res_zero, res_neg);
    else
      nxt_flags = cur_flags;
  end

endmodule

// File: rtl/lu_state_reg.sv
module lu_state_reg
  import logic_flag_unit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] flags_d,
  input  logic              res_load,
  input  logic [DATA_W-1:0] res_d,
  input  logic              we_d,
  output logic [FLAG_W-1:0] flags_q,
  output logic [DATA_W-1:0] res_q,
  output logic              we_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      res_q   <= '0;
      we_q    <= 1'b0;
    end else begin
      flags_q <= flags_d;
      we_q    <= we_d;
      if (res_load) res_q <= res_d;
    end
  end

endmodule

// File: rtl/logic_flag_unit.sv
module logic_flag_unit
  import logic_flag_unit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_sel,
  input  logic [DATA_W-1:0] dst_in,
  input  logic [DATA_W-1:0] src_in,
  input  logic              fw_req,
  input  logic [FLAG_W-1:0] fw_data,
  output logic [DATA_W-1:0] result,
  output logic              dst_we,
  output logic [FLAG_W-1:0] flags,
  output logic              cond_c,
  output logic              cond_z,
  output logic              cond_s,
  output logic              cond_v
);

  lu_op_e            op_kind;
  logic [DATA_W-1:0] calc_value;
  logic              calc_zero;
  logic              calc_neg;
  logic              calc_wb;
  logic [FLAG_W-1:0] flags_next;
  logic              ev_op_update;
  logic              ev_sw_write;
  logic              wb_fire;

  assign op_kind = lu_op_e'(op_sel);
  assign wb_fire = op_valid & calc_wb;

  lu_operate #(.DATA_W(DATA_W)) u_operate (
    .op         (op_kind),
    .opa        (dst_in),
    .opb        (src_in),
    .value      (calc_value),
    .value_zero (calc_zero),
    .value_neg  (calc_neg),
    .wants_wb   (calc_wb)
  );

  lu_flag_next u_flag_next (
    .cur_flags    (flags),
    .op_fire      (op_valid),
    .res_zero     (calc_zero),
    .res_neg      (calc_neg),
    .wr_req       (fw_req),
    .wr_data      (fw_data),
    .nxt_flags    (flags_next),
    .ev_op_update (ev_op_update),
    .ev_sw_write  (ev_sw_write)
  );

  lu_state_reg #(.DATA_W(DATA_W)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .flags_d  (flags_next),
    .res_load (op_valid),
    .res_d    (calc_value),
    .we_d     (wb_fire),
    .flags_q  (flags),
    .res_q    (result),
    .we_q     (dst_we)
  );

  assign cond_c = flags[FL_C];
  assign cond_z = flags[FL_Z];
  assign cond_s = flags[FL_S];
  assign cond_v = flags[FL_V];

endmodule

// File: rtl/logic_flag_unit_chk.sv
module logic_flag_unit_chk
  import logic_flag_unit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_sel,
  input logic [DATA_W-1:0] dst_in,
  input logic [DATA_W-1:0] src_in,
  input logic              fw_req,
  input logic [FLAG_W-1:0] fw_data,
  input logic [DATA_W-1:0] result,
  input logic              dst_we,
  input logic [FLAG_W-1:0] flags,
  input logic              ev_op_update,
  input logic              ev_sw_write
);

  p_xor_writes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_sel) |=> (dst_we && result == $past(dst_in ^ src_in)));

  p_we_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> $past(op_valid && !op_sel));

  p_test_no_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel) |=> (!dst_we && result == $past(dst_in & src_in)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_op_update |=> !flags[FL_V]);

  p_zero_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_op_update |=> (flags[FL_Z] == (result == '0) && flags[FL_S] == result[DATA_W-1]));

  p_keep_cdh_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_op_update |=> (flags[FL_C] == $past(flags[FL_C]) &&
                      flags[FL_D] == $past(flags[FL_D]) &&
                      flags[FL_H] == $past(flags[FL_H])));

  p_user_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fw_req |=> (flags[FL_F2:FL_F1] == $past(flags[FL_F2:FL_F1])));

  p_sw_write_r7_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sw_write |=> (flags == $past(fw_data)));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !fw_req) |=> ($stable(flags) && $stable(result) && !dst_we));

endmodule

bind logic_flag_unit logic_flag_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_valid     (op_valid),
  .op_sel       (op_sel),
  .dst_in       (dst_in),
  .src_in       (src_in),
  .fw_req       (fw_req),
  .fw_data      (fw_data),
  .result       (result),
  .dst_we       (dst_we),
  .flags        (flags),
  .ev_op_update (ev_op_update),
  .ev_sw_write  (ev_sw_write)
);

// File: tb/logic_flag_unit_bench.sv
`timescale 1ns/1ps
module logic_flag_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic       op_sel = 1'b0;
  logic [7:0] dst_in = '0;
  logic [7:0] src_in = '0;
  logic       fw_req = 1'b0;
  logic [7:0] fw_data = '0;
  logic [7:0] result;
  logic       dst_we;
  logic [7:0] flags;
  logic       cond_c, cond_z, cond_s, cond_v;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_flags = '0;
  logic [7:0] m_res = '0;
  logic       m_we = 1'b0;

  always #5 clk = ~clk;

  logic_flag_unit u_logic_flag_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .dst_in(dst_in), .src_in(src_in), .fw_req(fw_req), .fw_data(fw_data),
    .result(result), .dst_we(dst_we), .flags(flags),
    .cond_c(cond_c), .cond_z(cond_z), .cond_s(cond_s), .cond_v(cond_v)
  );

  function automatic logic [7:0] bench_value(input logic sel, input logic [7:0] a, input logic [7:0] b);
    return sel ? (a & b) : (a ^ b);
  endfunction

  // Flags after one cycle: write wins, else Z/S from the value, V cleared, rest kept.
  function automatic logic [7:0] bench_flags(input logic [7:0] cur, input logic valid,
                                             input logic [7:0] v, input logic wr, input logic [7:0] wd);
    if (wr) return wd;
    if (!valid) return cur;
    return {cur[7], (v == 8'h00), v[7], 1'b0, cur[3:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic s, input logic [7:0] a, input logic [7:0] b,
                      input logic w, input logic [7:0] wd);
    logic [7:0] val;
    @(negedge clk);
    op_valid = v; op_sel = s; dst_in = a; src_in = b; fw_req = w; fw_data = wd;
    val = bench_value(s, a, b);
    m_flags = bench_flags(m_flags, v, val, w, wd);
    if (v) m_res = val;
    m_we = v && !s;
    @(posedge clk);
    #1;
    check(s ? "R2 result" : "R1 result", result, m_res);
    check(s ? "R2 dst_we" : "R1 dst_we", dst_we, m_we);
    check(w ? "R7 R8 flags" : "R3 R4 R5 R6 R11 flags", flags, m_flags);
    check("R9 cond", {cond_c, cond_z, cond_s, cond_v}, m_flags[7:4]);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R10 flags", flags, 8'h00);
    check("R10 result", result, 8'h00);
    check("R10 dst_we", dst_we, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    step(1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 8'hFF);   // R7 all ones
    step(1'b1, 1'b0, 8'h5A, 8'h5A, 1'b0, 8'h00);   // R1 R4 zero result, expect 0xCF
    check("R5 R6 directed", flags, 8'hCF);
    step(1'b1, 1'b1, 8'h80, 8'hFF, 1'b0, 8'h00);   // R2 R4 negative, expect 0xAF
    check("R4 directed sign", flags, 8'hAF);
    step(1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00);   // R11 idle
    step(1'b1, 1'b0, 8'hF0, 8'h0F, 1'b1, 8'h13);   // R8 write wins
    check("R8 directed", flags, 8'h13);
    step(1'b1, 1'b1, 8'h0F, 8'hF0, 1'b0, 8'h00);   // R2 zero test
    step(1'b1, 1'b0, 8'h01, 8'h81, 1'b0, 8'h00);   // R1 back-to-back
    step(1'b1, 1'b0, 8'h01, 8'h00, 1'b0, 8'h00);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[2], 8'($urandom), (r[5:3] == 3'd0) ? 8'h00 : 8'($urandom),
           (r[8:6] == 3'd0), 8'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule